// File: doc/BRIEF.md
# Multi-Mode Channel Pattern Source Selector

This block feeds a bank of parallel output channels, 16 by default, from one of three pattern sources. The first source is an externally generated pseudo-random word that passes straight through. The second is a programmable static word. The third is a square wave that is copied onto every channel. A 2-bit source select picks the pattern. The chosen word is captured in an output register, so every output bit changes only on a clock edge.

The static word is written one half at a time over a shared byte-wide bus. One load strobe writes the high half and a second strobe writes the low half. The square wave comes from a free-running counter. A 2-bit rate select sets its period, and the counter starts again from zero whenever the rate select changes. A registered flag marks the cycles in which the output carries the pseudo-random source, because only that source is fit for bit-error measurement.

Top module: `pattern_source_sel`

## Requirements
- R1: While reset is asserted, the channel outputs and the measurement flag are all zero. The static word also resets to zero, so static mode right after reset outputs zero.
- R2: When the source select is 00, the channel outputs after a clock edge equal the pseudo-random input word sampled at that edge.
- R3: A clock edge with the high-half strobe set copies the load bus into static bits 15 to 8 and leaves bits 7 to 0 unchanged.
- R4: A clock edge with the low-half strobe set copies the load bus into static bits 7 to 0 and leaves bits 15 to 8 unchanged. With both strobes set, the bus value goes into both halves.
- R5: When the source select is 01, the outputs show the static word as it stood before the edge. The word keeps its value while both strobes are low, whatever the bus carries. Strobes take effect under every source select.
- R6: When the source select is 10, all channels carry the same bit, so the output word is all zeros or all ones.
- R7: The rate select codes 00, 01, 10 and 11 give a square-wave period of 2, 4, 8 and 16 clock cycles, each half low and half high.
- R8: At an edge where the rate select differs from its value at the previous edge, the divide counter restarts. From the next edge on, the square-wave output is low for 2^rate cycles, then high for 2^rate cycles, and then repeats.
- R9: When the source select is 11, the outputs are all zero.
- R10: The measurement flag is high after an edge exactly when the source select sampled at that edge was 00.
- R11: A change of the source select shows on the outputs at the first clock edge that samples the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 2 | Source select: 00 pseudo-random, 01 static, 10 square wave, 11 reserved (zeros) |
| rate_sel_i | input | 2 | Square-wave rate select |
| prbs_word_i | input | 16 | Pseudo-random word to pass through |
| load_bus_i | input | 8 | Shared bus for static word loads |
| load_hi_i | input | 1 | Strobe that loads the bus into static bits 15:8 |
| load_lo_i | input | 1 | Strobe that loads the bus into static bits 7:0 |
| chan_o | output | 16 | Registered channel outputs |
| meas_ok_o | output | 1 | Registered flag, high when the outputs carry the pseudo-random source |

## Verification
The bench loads each static half on its own and checks that the other half is not disturbed. A design that decoded the strobes the wrong way round, or that wrote the whole word at once, would show a wrong byte on the outputs. It also changes the rate select while the wave is mid-period and checks the first 32 samples after each restart against the expected period and phase. A counter that did not restart would show the wrong phase, and a wrong counter tap would show the wrong period. Random mode switching checks the one-cycle latency, the all-zero output of the reserved code and the timing of the measurement flag. A stale or combinational output path would be off by one cycle at those switch points.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [1:0] {
        SRC_PRBS   = 2'b00,
        SRC_STATIC = 2'b01,
        SRC_SQUARE = 2'b10,
        SRC_RSVD   = 2'b11
    } src_e;
endpackage

// File: rtl/pss_static_word.sv
module pss_static_word #(
    parameter int NUM_CH = 16,
    localparam int HALF_W = NUM_CH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] bus_i,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    output logic [NUM_CH-1:0] word_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] word;
    } st_t;

    st_t st_d, st_q;
    logic [1:0] ld_vec;

    assign ld_vec = {ld_hi_i, ld_lo_i};

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < 2; h++) begin
            if (ld_vec[h]) begin
                st_d.word[h*HALF_W +: HALF_W] = bus_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
endmodule

// File: rtl/pss_square.sv
module pss_square #(
    parameter int RATE_W = 2,
    localparam int CNT_W = 2 ** RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel_i,
    output logic              wave_o
);
    typedef struct packed {
        logic [RATE_W-1:0] sel;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rate_sel_i != st_q.sel) begin
            st_d.sel = rate_sel_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Counter bit k toggles every 2^k cycles, giving a period of 2^(k+1).
    assign wave_o = st_q.cnt[st_q.sel];
endmodule

// File: rtl/pss_out_stage.sv
module pss_out_stage
    import pss_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_e              src_i,
    input  logic [NUM_CH-1:0] prbs_i,
    input  logic [NUM_CH-1:0] static_i,
    input  logic              wave_i,
    output logic [NUM_CH-1:0] chan_o,
    output logic              meas_ok_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] chan;
        logic              meas;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_CH-1:0] wave_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_fan
        assign wave_vec[c] = wave_i;
    end

    always_comb begin
        st_d.meas = (src_i == SRC_PRBS);
        unique case (src_i)
            SRC_PRBS:   st_d.chan = prbs_i;
            SRC_STATIC: st_d.chan = static_i;
            SRC_SQUARE: st_d.chan = wave_vec;
            default:    st_d.chan = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_o    = st_q.chan;
    assign meas_ok_o = st_q.meas;
endmodule

// File: rtl/pattern_source_sel.sv
module pattern_source_sel
    import pss_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int RATE_W = 2,
    localparam int HALF_W = NUM_CH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel_i,
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic [NUM_CH-1:0] prbs_word_i,
    input  logic [HALF_W-1:0] load_bus_i,
    input  logic              load_hi_i,
    input  logic              load_lo_i,
    output logic [NUM_CH-1:0] chan_o,
    output logic              meas_ok_o
);
    logic [NUM_CH-1:0] static_word;
    logic              wave;

    pss_static_word #(.NUM_CH(NUM_CH)) u_static (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_i   (load_bus_i),
        .ld_hi_i (load_hi_i),
        .ld_lo_i (load_lo_i),
        .word_o  (static_word)
    );

    pss_square #(.RATE_W(RATE_W)) u_square (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (rate_sel_i),
        .wave_o     (wave)
    );

    pss_out_stage #(.NUM_CH(NUM_CH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_e'(src_sel_i)),
        .prbs_i    (prbs_word_i),
        .static_i  (static_word),
        .wave_i    (wave),
        .chan_o    (chan_o),
        .meas_ok_o (meas_ok_o)
    );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int NUM_CH = 16,
    parameter int RATE_W = 2,
    localparam int HALF_W = NUM_CH / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        src_sel_i,
    input logic [RATE_W-1:0] rate_sel_i,
    input logic [NUM_CH-1:0] prbs_word_i,
    input logic [HALF_W-1:0] load_bus_i,
    input logic              load_hi_i,
    input logic              load_lo_i,
    input logic [NUM_CH-1:0] chan_o,
    input logic              meas_ok_o
);
    a_r2_prbs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel_i) == 2'b00) |-> chan_o == $past(prbs_word_i));

    a_r3_upper_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(load_hi_i, 2) && $past(src_sel_i) == 2'b01)
        |-> chan_o[NUM_CH-1:HALF_W] == $past(load_bus_i, 2));

    a_r6_sq_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel_i) == 2'b10) |-> (chan_o == '0 || chan_o == '1));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel_i) == 2'b11) |-> chan_o == '0);

    a_r10_meas_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> meas_ok_o == ($past(src_sel_i) == 2'b00));
endmodule

bind pattern_source_sel pss_checker #(.NUM_CH(NUM_CH), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/pattern_source_sel_bench.sv
`timescale 1ns/1ps
module pattern_source_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [1:0]  rate_sel = 2'b00;
    logic [15:0] prbs = '0;
    logic [7:0]  bus = '0;
    logic        ld_hi = 1'b0;
    logic        ld_lo = 1'b0;
    logic [15:0] chan;
    logic        meas;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_static = '0;
    int          m_cnt = 0;
    int          m_sel = 0;

    always #2.5 clk = ~clk;

    pattern_source_sel u_pattern_source_sel (
        .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel), .rate_sel_i(rate_sel),
        .prbs_word_i(prbs), .load_bus_i(bus), .load_hi_i(ld_hi), .load_lo_i(ld_lo),
        .chan_o(chan), .meas_ok_o(meas)
    );

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R9";
        endcase
    endfunction

    // One clock: expected output from the requirement model, then model update.
    task automatic tick(string tag);
        logic [15:0] exp;
        logic        exp_meas;
        @(posedge clk);
        case (src_sel)
            2'b00:   exp = prbs;
            2'b01:   exp = m_static;
            2'b10:   exp = ((m_cnt >> m_sel) & 1) != 0 ? 16'hFFFF : 16'h0000;
            default: exp = 16'h0000;
        endcase
        exp_meas = (src_sel == 2'b00);
        if (ld_hi) m_static[15:8] = bus;
        if (ld_lo) m_static[7:0] = bus;
        if (int'(rate_sel) != m_sel) begin
            m_sel = int'(rate_sel);
            m_cnt = 0;
        end else begin
            m_cnt = (m_cnt + 1) % 16;
        end
        @(negedge clk);
        chk(chan == exp, (tag == "") ? tag_of(src_sel) : tag, chan, exp);
        chk(meas == exp_meas, "R10", {15'd0, meas}, {15'd0, exp_meas});
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        src_sel = 2'b01;
        prbs = 16'hFFFF;
        repeat (4) @(negedge clk);
        chk(chan == 16'h0, "R1", chan, 16'h0);
        chk(meas == 1'b0, "R1", {15'd0, meas}, 16'h0);
        rst_n = 1'b1;
        tick("R1");

        // Directed static loads
        bus = 8'hA5; ld_hi = 1'b1; tick("R3");
        ld_hi = 1'b0; bus = 8'h11; tick("R3");
        chk(chan == 16'hA500, "R3", chan, 16'hA500);
        bus = 8'h3C; ld_lo = 1'b1; tick("R4");
        ld_lo = 1'b0; bus = 8'hEE; tick("R4");
        chk(chan == 16'hA53C, "R4", chan, 16'hA53C);
        bus = 8'h77; ld_hi = 1'b1; ld_lo = 1'b1; tick("R4");
        ld_hi = 1'b0; ld_lo = 1'b0; tick("R4");
        chk(chan == 16'h7777, "R4", chan, 16'h7777);
        for (int i = 0; i < 4; i++) begin
            bus = 8'(i * 37 + 5);
            tick("R5");
        end
        chk(chan == 16'h7777, "R5", chan, 16'h7777);

        // Load while another source is selected
        src_sel = 2'b11; bus = 8'h9B; ld_lo = 1'b1; tick("R9");
        ld_lo = 1'b0; tick("R9");
        chk(chan == 16'h0, "R9", chan, 16'h0);
        src_sel = 2'b01; tick("R5");
        chk(chan == 16'h779B, "R5", chan, 16'h779B);

        // Mode change takes effect on the next edge
        src_sel = 2'b00; prbs = 16'hC0DE; tick("R11");
        chk(chan == 16'hC0DE, "R11", chan, 16'hC0DE);
        src_sel = 2'b11; tick("R11");
        chk(chan == 16'h0, "R11", chan, 16'h0);

        // Square wave periods and restart
        src_sel = 2'b10;
        for (int s = 1; s <= 4; s++) begin
            int sr;
            logic [15:0] e;
            sr = s % 4;
            rate_sel = 2'(sr);
            tick("R8");
            for (int k = 1; k <= 32; k++) begin
                tick("R6");
                e = (((k - 1) >> sr) & 1) != 0 ? 16'hFFFF : 16'h0000;
                chk(chan == e, (k <= (1 << sr)) ? "R8" : "R7", chan, e);
            end
        end

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 8;
            src_sel = (r < 3) ? 2'b00 : (r < 5) ? 2'b01 : (r < 7) ? 2'b10 : 2'b11;
            if ($urandom % 16 == 0) rate_sel = 2'($urandom % 4);
            prbs = 16'($urandom);
            bus = 8'($urandom);
            ld_hi = ($urandom % 4) == 0;
            ld_lo = ($urandom % 4) == 0;
            tick("");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule